// File: doc/BRIEF.md
# E1 Far-End Block Error Counter

This block counts far-end block error indications carried in the E-bits of an E1 line that runs CRC-4 multiframing. On each frame strobe it looks at the first bit of timeslot 0. If the strobe falls on one of the two multiframe positions that carry E-bits, and that bit is zero, the block adds one to a running 16-bit count. Frame alignment, CRC-4 checking and CAS multiframe recovery sit outside this block. Their results arrive as level flags.

Counting is allowed only in E1 mode and only while both frame-alignment sync and CRC-4 multiframe sync are held. Losing CAS multiframe sync by itself does not stop the count. A once-per-second update strobe copies the running count into a host-visible hold register and restarts the running count in the same cycle.

The host reads the held count as two bytes over a plain address and read-enable port. The read data is registered.

Top module: `e1feb_counter`

## Requirements
- R1: While `rst` is high, the running count, the held count and `rd_data` all go to zero.
- R2: A frame strobe with `frm_idx` equal to 13 or 15 and `ts0_bit1` equal to 0 adds one to the running count at the same clock edge. This applies when `e1_mode`, `fas_sync` and `crc4_sync` are all high.
- R3: A strobed E-bit position whose `ts0_bit1` is 1 leaves the running count unchanged.
- R4: A zero bit leaves the count unchanged when it arrives at any `frm_idx` other than 13 or 15, or when `frm_stb` is low.
- R5: While `fas_sync` or `crc4_sync` is low, no E-bit is counted.
- R6: When `cas_sync` is low and the other conditions of R2 hold, zero E-bits are still counted.
- R7: While `e1_mode` is low, no E-bit is counted.
- R8: A `sec_stb` cycle copies the running count, as it stood before that edge, into the held count. The same edge sets the running count to 1 if a qualifying zero E-bit arrives in that cycle, and to 0 otherwise.
- R9: A read with `rd_en` high returns the held count on `rd_data` one cycle later. Address 0x48 returns bits 15:8 and address 0x49 returns bits 7:0.
- R10: One cycle after any other address, or after `rd_en` is low, `rd_data` is 0.
- R11: The running count has no saturation. After 65536 counted E-bits it wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| e1_mode | input | 1 | High selects E1 operation; counting is only allowed when this is high |
| fas_sync | input | 1 | Frame alignment sync held |
| crc4_sync | input | 1 | CRC-4 multiframe sync held |
| cas_sync | input | 1 | CAS multiframe sync held (no effect on counting) |
| frm_stb | input | 1 | One-cycle strobe marking a valid timeslot-0 sample |
| frm_idx | input | 4 | Frame number within the 16-frame multiframe |
| ts0_bit1 | input | 1 | Value of the first bit of timeslot 0 |
| sec_stb | input | 1 | One-second strobe: latch the count and restart it |
| rd_en | input | 1 | Host read enable |
| rd_addr | input | 8 | Host read address |
| rd_data | output | 8 | Registered read data |

## Verification
The running count changes at the same rising edge that sees a qualifying frame strobe. The held count changes at the edge that sees `sec_stb`. `rd_data` reflects the held count one edge after `rd_en`, so a count latched by `sec_stb` becomes readable with a read issued in the following cycle. The bench drives inputs on falling edges and updates its reference model right after each rising edge. It compares `rd_data` at the next falling edge, which places every comparison exactly one register stage after its stimulus. Directed cases check known literal totals, including a full 65536-event wrap. A seeded random phase compares every cycle's read data against the model.

// File: rtl/e1feb_pkg.sv
package e1feb_pkg;

    localparam int unsigned FRAME_IDX_W = 4;

    typedef struct packed {
        logic                   strobe;
        logic [FRAME_IDX_W-1:0] idx;
        logic                   bit1;
    } ts0_sample_t;

    typedef struct packed {
        logic e1_mode;
        logic fas_ok;
        logic crc_ok;
        logic cas_ok;
    } sync_state_t;

    function automatic logic is_ebit_slot(
        input logic [FRAME_IDX_W-1:0] idx,
        input logic [FRAME_IDX_W-1:0] slot_a,
        input logic [FRAME_IDX_W-1:0] slot_b
    );
        return (idx == slot_a) || (idx == slot_b);
    endfunction

endpackage

// File: rtl/e1feb_qualify.sv
module e1feb_qualify
    import e1feb_pkg::*;
#(
    parameter int unsigned SLOT_A           = 13,
    parameter int unsigned SLOT_B           = 15,
    parameter bit          CAS_LOSS_FREEZES = 1'b0
) (
    input  ts0_sample_t sample,
    input  sync_state_t sync,
    output logic        err_hit
);

    localparam logic [FRAME_IDX_W-1:0] SLOT_A_L = FRAME_IDX_W'(SLOT_A);
    localparam logic [FRAME_IDX_W-1:0] SLOT_B_L = FRAME_IDX_W'(SLOT_B);

    logic sync_allows;
    logic at_ebit;

    generate
        if (CAS_LOSS_FREEZES) begin : g_cas_gate
            assign sync_allows = sync.e1_mode & sync.fas_ok & sync.crc_ok & sync.cas_ok;
        end else begin : g_cas_free
            logic cas_ignored;
            assign cas_ignored = sync.cas_ok | 1'b1;
            assign sync_allows = sync.e1_mode & sync.fas_ok & sync.crc_ok & cas_ignored;
        end
    endgenerate

    always_comb begin
        at_ebit = sample.strobe && is_ebit_slot(sample.idx, SLOT_A_L, SLOT_B_L);
        err_hit = sync_allows && at_ebit && !sample.bit1;
    end

endmodule

// File: rtl/e1feb_accum.sv
module e1feb_accum #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             err_hit,
    input  logic             sec_stb,
    output logic [CNT_W-1:0] run_cnt,
    output logic [CNT_W-1:0] hold_cnt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt  <= '0;
            hold_cnt <= '0;
        end else if (sec_stb) begin
            hold_cnt <= run_cnt;
            run_cnt  <= err_hit ? ONE : '0;
        end else if (err_hit) begin
            run_cnt  <= run_cnt + ONE;
        end
    end

endmodule

// File: rtl/e1feb_rdport.sv
module e1feb_rdport #(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned BYTE_W    = 8,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned BASE_ADDR = 'h48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  hold_cnt,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int unsigned       NBYTES = CNT_W / BYTE_W;
    localparam logic [ADDR_W-1:0] BASE_L = ADDR_W'(BASE_ADDR);

    logic [BYTE_W-1:0] byte_lane [NBYTES];
    logic [ADDR_W-1:0] offset;
    logic [BYTE_W-1:0] sel_byte;

    generate
        for (genvar g = 0; g < NBYTES; g++) begin : g_lane
            assign byte_lane[g] = hold_cnt[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    always_comb begin
        offset   = rd_addr - BASE_L;
        sel_byte = '0;
        for (int k = 0; k < NBYTES; k++) begin
            if (offset == ADDR_W'(k)) begin
                sel_byte = byte_lane[NBYTES-1-k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_en ? sel_byte : '0;
        end
    end

endmodule

// File: rtl/e1feb_counter.sv
module e1feb_counter
    import e1feb_pkg::*;
#(
    parameter int unsigned CNT_W            = 16,
    parameter int unsigned BYTE_W           = 8,
    parameter int unsigned ADDR_W           = 8,
    parameter int unsigned BASE_ADDR        = 'h48,
    parameter int unsigned SLOT_A           = 13,
    parameter int unsigned SLOT_B           = 15,
    parameter bit          CAS_LOSS_FREEZES = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   e1_mode,
    input  logic                   fas_sync,
    input  logic                   crc4_sync,
    input  logic                   cas_sync,
    input  logic                   frm_stb,
    input  logic [FRAME_IDX_W-1:0] frm_idx,
    input  logic                   ts0_bit1,
    input  logic                   sec_stb,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [BYTE_W-1:0]      rd_data
);

    ts0_sample_t      sample;
    sync_state_t      sync;
    logic             err_hit;
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] hold_cnt;

    always_comb begin
        sample.strobe = frm_stb;
        sample.idx    = frm_idx;
        sample.bit1   = ts0_bit1;
        sync.e1_mode  = e1_mode;
        sync.fas_ok   = fas_sync;
        sync.crc_ok   = crc4_sync;
        sync.cas_ok   = cas_sync;
    end

    e1feb_qualify #(
        .SLOT_A           (SLOT_A),
        .SLOT_B           (SLOT_B),
        .CAS_LOSS_FREEZES (CAS_LOSS_FREEZES)
    ) qual_i (
        .sample  (sample),
        .sync    (sync),
        .err_hit (err_hit)
    );

    e1feb_accum #(
        .CNT_W (CNT_W)
    ) accum_i (
        .clk      (clk),
        .rst      (rst),
        .err_hit  (err_hit),
        .sec_stb  (sec_stb),
        .run_cnt  (run_cnt),
        .hold_cnt (hold_cnt)
    );

    e1feb_rdport #(
        .CNT_W     (CNT_W),
        .BYTE_W    (BYTE_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) rdport_i (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .hold_cnt (hold_cnt),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/e1feb_counter_chk.sv
module e1feb_counter_chk #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned BYTE_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             e1_mode,
    input logic             fas_sync,
    input logic             crc4_sync,
    input logic             frm_stb,
    input logic             sec_stb,
    input logic             rd_en,
    input logic             err_hit,
    input logic [CNT_W-1:0] run_cnt,
    input logic [CNT_W-1:0] hold_cnt,
    input logic [BYTE_W-1:0] rd_data
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (run_cnt == '0 && hold_cnt == '0 && rd_data == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (err_hit && !sec_stb) |=> run_cnt == $past(run_cnt) + CNT_W'(1));

    // R4
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!frm_stb && !sec_stb) |=> $stable(run_cnt));

    // R5
    sync_loss_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((!fas_sync || !crc4_sync) && !sec_stb) |=> $stable(run_cnt));

    // R7
    mode_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!e1_mode && !sec_stb) |=> $stable(run_cnt));

    // R8
    latch_copy_chk: assert property (@(posedge clk) disable iff (rst)
        sec_stb |=> hold_cnt == $past(run_cnt));

    // R8
    latch_steady_chk: assert property (@(posedge clk) disable iff (rst)
        !sec_stb |=> $stable(hold_cnt));

    // R10
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rd_data == '0);

endmodule

bind e1feb_counter e1feb_counter_chk #(
    .CNT_W  (CNT_W),
    .BYTE_W (BYTE_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .e1_mode   (e1_mode),
    .fas_sync  (fas_sync),
    .crc4_sync (crc4_sync),
    .frm_stb   (frm_stb),
    .sec_stb   (sec_stb),
    .rd_en     (rd_en),
    .err_hit   (err_hit),
    .run_cnt   (run_cnt),
    .hold_cnt  (hold_cnt),
    .rd_data   (rd_data)
);

// File: tb/e1feb_counter_tb_top.sv
module e1feb_counter_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       e1_mode, fas_sync, crc4_sync, cas_sync;
    logic       frm_stb, ts0_bit1, sec_stb, rd_en;
    logic [3:0] frm_idx;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    logic [15:0] m_run  = '0;
    logic [15:0] m_hold = '0;
    logic [7:0]  exp_rd = '0;
    logic [7:0]  seen_rd;
    bit          pend   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    e1feb_counter dut_i (
        .clk(clk), .rst(rst), .e1_mode(e1_mode), .fas_sync(fas_sync),
        .crc4_sync(crc4_sync), .cas_sync(cas_sync), .frm_stb(frm_stb),
        .frm_idx(frm_idx), .ts0_bit1(ts0_bit1), .sec_stb(sec_stb),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic hit_f(logic stb, logic [3:0] idx, logic bt,
                                   logic e1, logic fas, logic crc);
        return stb && e1 && fas && crc && (idx == 4'd13 || idx == 4'd15) && !bt;
    endfunction

    function automatic logic [7:0] rd_f(logic [15:0] hold, logic rd, logic [7:0] addr);
        if (!rd)            return 8'h00;
        if (addr == 8'h48)  return hold[15:8];
        if (addr == 8'h49)  return hold[7:0];
        return 8'h00;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic stb, input logic [3:0] idx, input logic bt,
                         input logic e1, input logic fas, input logic crc,
                         input logic cas, input logic sec, input logic rd,
                         input logic [7:0] addr);
        logic h;
        @(negedge clk);
        seen_rd = rd_data;
        if (pend) check(rd_data == exp_rd, "R9/R10 random read", rd_data, exp_rd);
        pend      = 1'b0;
        frm_stb   = stb;  frm_idx  = idx;  ts0_bit1 = bt;
        e1_mode   = e1;   fas_sync = fas;  crc4_sync = crc; cas_sync = cas;
        sec_stb   = sec;  rd_en    = rd;   rd_addr  = addr;
        @(posedge clk);
        h      = hit_f(stb, idx, bt, e1, fas, crc);
        exp_rd = rd_f(m_hold, rd, addr);
        if (sec) begin
            m_hold = m_run;
            m_run  = h ? 16'd1 : 16'd0;
        end else if (h) begin
            m_run = m_run + 16'd1;
        end
    endtask

    task automatic idle();
        drive(0, 4'd0, 1, 1, 1, 1, 1, 0, 0, 8'h00);
    endtask

    task automatic ebit(input logic [3:0] idx, input logic bt, input logic e1,
                        input logic fas, input logic crc, input logic cas);
        drive(1, idx, bt, e1, fas, crc, cas, 0, 0, 8'h00);
    endtask

    task automatic latch();
        drive(0, 4'd0, 1, 1, 1, 1, 1, 1, 0, 8'h00);
    endtask

    task automatic read_hold(input string req, input logic [15:0] expv);
        logic [7:0] hi;
        drive(0, 4'd0, 1, 1, 1, 1, 1, 0, 1, 8'h48);
        drive(0, 4'd0, 1, 1, 1, 1, 1, 0, 1, 8'h49);
        hi = seen_rd;
        idle();
        check({hi, seen_rd} == expv, req, {hi, seen_rd}, expv);
    endtask

    task automatic read_one(input string req, input logic rd, input logic [7:0] addr,
                            input logic [7:0] expv);
        drive(0, 4'd0, 1, 1, 1, 1, 1, 0, rd, addr);
        idle();
        check(seen_rd == expv, req, seen_rd, expv);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed = 32'h1E1B;
        void'($urandom(seed));
        rst = 1'b1;
        frm_stb = 0; frm_idx = 0; ts0_bit1 = 1; e1_mode = 1; fas_sync = 1;
        crc4_sync = 1; cas_sync = 1; sec_stb = 0; rd_en = 0; rd_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rd_data == 8'h00, "R1 rd_data after reset", rd_data, 0);
        rst = 1'b0;
        read_hold("R1 held count after reset", 16'h0000);
        latch();
        read_hold("R1 running count after reset", 16'h0000);

        // R2: three zero E-bits at frames 13 and 15
        ebit(4'd13, 0, 1, 1, 1, 1);
        ebit(4'd15, 0, 1, 1, 1, 1);
        idle();
        ebit(4'd15, 0, 1, 1, 1, 1);
        latch();
        read_hold("R2 zero E-bits counted", 16'd3);

        // R3: E-bit of one not counted
        for (int i = 0; i < 4; i++) ebit(i[0] ? 4'd13 : 4'd15, 1, 1, 1, 1, 1);
        latch();
        read_hold("R3 one-valued E-bits ignored", 16'd0);

        // R4: other frames and missing strobe
        for (int i = 0; i < 16; i++)
            if (i != 13 && i != 15) ebit(4'(i), 0, 1, 1, 1, 1);
        drive(0, 4'd13, 0, 1, 1, 1, 1, 0, 0, 8'h00);
        drive(0, 4'd15, 0, 1, 1, 1, 1, 0, 0, 8'h00);
        latch();
        read_hold("R4 non E-bit frames ignored", 16'd0);

        // R5: FAS or CRC-4 sync lost
        ebit(4'd13, 0, 1, 0, 1, 1);
        ebit(4'd15, 0, 1, 1, 0, 1);
        ebit(4'd13, 0, 1, 0, 0, 1);
        latch();
        read_hold("R5 sync loss freezes count", 16'd0);

        // R6: CAS loss only
        ebit(4'd13, 0, 1, 1, 1, 0);
        ebit(4'd15, 0, 1, 1, 1, 0);
        latch();
        read_hold("R6 CAS loss still counts", 16'd2);

        // R7: T1 mode
        ebit(4'd13, 0, 0, 1, 1, 1);
        ebit(4'd15, 0, 0, 1, 1, 1);
        latch();
        read_hold("R7 non-E1 mode ignored", 16'd0);

        // R8: coincident error lands in new interval
        for (int i = 0; i < 5; i++) ebit(4'd13, 0, 1, 1, 1, 1);
        drive(1, 4'd15, 0, 1, 1, 1, 1, 1, 0, 8'h00);
        read_hold("R8 latched value excludes coincident hit", 16'd5);
        latch();
        read_hold("R8 coincident hit starts new interval", 16'd1);

        // R9: both bytes nonzero (300 = 0x012C)
        for (int i = 0; i < 300; i++) ebit(4'd15, 0, 1, 1, 1, 1);
        latch();
        read_one("R9 high byte at 0x48", 1, 8'h48, 8'h01);
        read_one("R9 low byte at 0x49", 1, 8'h49, 8'h2C);

        // R10: other addresses, disabled read
        read_one("R10 address 0x47", 1, 8'h47, 8'h00);
        read_one("R10 address 0x4A", 1, 8'h4A, 8'h00);
        read_one("R10 address 0x00", 1, 8'h00, 8'h00);
        read_one("R10 rd_en low", 0, 8'h49, 8'h00);

        // R11: wrap after 65536 events
        latch();
        for (int i = 0; i < 65536; i++) ebit(4'd13, 0, 1, 1, 1, 1);
        ebit(4'd13, 0, 1, 1, 1, 1);
        latch();
        read_hold("R11 count wraps without saturation", 16'd1);

        // Random phase, R2..R10 against the model
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom();
            logic [7:0]  a = 8'h46 + 8'(r[20:18]);
            drive(r[0], r[4:1], r[5], r[6] | r[7], r[8] | r[9], r[10] | r[11],
                  r[12], (r[17:13] == 5'd0), r[21], a);
            pend = 1'b1;
        end
        idle();
        latch();
        read_hold("R8 final random-phase total", m_hold);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule